// File: doc/BRIEF.md
# Maskable Interrupt Flag Register

This block gathers the event sources of a storage-card host controller into one 16-bit flag register. A 16-bit mask register selects which flags may raise the single interrupt line. Most flags latch when their source pulses for a cycle. They then stay set until software writes a one to that bit position.

Two positions work differently. These are the receive-FIFO read request and the transmit-FIFO write request. They are level requests that follow a FIFO threshold directly, so no clear write changes them.

Software reaches both registers through a small port. The port has a write strobe, a one-bit register select, write data and combinational read data. Raw flags are always readable whatever the mask holds, so a masked event can still be polled.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset the flag register reads 0x0000, the mask register reads 0xFFFF and the interrupt output is low.
- R2: A one-cycle pulse on a clearable event input sets the matching flag at the next clock edge. The flag then stays set until it is cleared.
- R3: A write with register select 0 (flags) clears every clearable flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R4: If an event pulse and a clearing write hit the same clearable bit in the same cycle, the flag is set after that edge.
- R5: Flag bit 5 (receive FIFO read request) and flag bit 6 (transmit FIFO write request) always read the current level of their request inputs. Clearing writes and event pulses on those positions have no effect on them.
- R6: Mask bit 1 disables the matching flag and mask bit 0 enables it. The interrupt output is the OR of all enabled flags, registered, so it follows the flags with one clock of delay.
- R7: Flags read back their true value while masked.
- R8: A write with register select 1 loads the mask from the write data. A flag write leaves the mask unchanged.
- R9: The clearable positions include bit 0 (transfer done), bit 1 (programming done), bit 2 (command response end) and bit 7 (card interrupt).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | Register select: 0 flags, 1 mask |
| reg_wdata | input | 16 | Write data (clear pattern or mask value) |
| reg_rdata | output | 16 | Read data of the selected register |
| evt_pulse | input | 16 | One-cycle event pulses, one per flag bit |
| rx_req_lvl | input | 1 | Receive FIFO threshold request level |
| tx_req_lvl | input | 1 | Transmit FIFO threshold request level |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clearing write and an event on the same bit in the same cycle. A clearing write aimed at a level-request bit while its request is held high is similarly awkward. The stimulus table drives a write strobe, a clear pattern and an event vector together in one vector. It also holds the FIFO levels across a clearing write. The flags are then read back right after that edge. The one-cycle interrupt latency is separated from the flag update by a directed test. That test unmasks a pending flag and samples the interrupt line before and after the following edge.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    typedef enum logic {
        SEL_FLAGS = 1'b0,
        SEL_MASK  = 1'b1
    } regsel_e;

    localparam int unsigned DEF_WIDTH  = 16;
    localparam int unsigned DEF_RX_BIT = 5;
    localparam int unsigned DEF_TX_BIT = 6;

endpackage

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank #(
    parameter int unsigned W     = 16,
    parameter int unsigned RX_BIT = 5,
    parameter int unsigned TX_BIT = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] evt,
    input  logic         rx_lvl,
    input  logic         tx_lvl,
    output logic [W-1:0] raw
);
    localparam logic [W-1:0] LVL_MASK = (W'(1) << RX_BIT) | (W'(1) << TX_BIT);

    typedef struct packed {
        logic [W-1:0] flags;
    } bank_t;

    bank_t        s_d, s_q;
    logic [W-1:0] clr_vec;
    logic [W-1:0] evt_vec;

    always_comb begin
        clr_vec    = clr_en ? (clr_bits & ~LVL_MASK) : '0;
        evt_vec    = evt & ~LVL_MASK;
        s_d        = s_q;
        // set takes priority over clear
        s_d.flags  = (s_q.flags & ~clr_vec) | evt_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == RX_BIT) begin : g_rx
            assign raw[i] = rx_lvl;
        end else if (i == TX_BIT) begin : g_tx
            assign raw[i] = tx_lvl;
        end else begin : g_lat
            assign raw[i] = s_q.flags[i];
        end
    end

    // R2
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.flags & $past(s_q.flags & ~clr_vec)) == $past(s_q.flags & ~clr_vec)));
    // R3
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.flags & $past(clr_vec & ~evt_vec)) == '0));
    // R4
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.flags & $past(evt_vec)) == $past(evt_vec)));

endmodule

// File: rtl/irqf_mask_reg.sv
module irqf_mask_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mreg_t;

    mreg_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr_en) m_d.mask = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '{mask: '1};
        else        m_q <= m_d;
    end

    assign mask = m_q.mask;

    // R8
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mask == $past(wdata)));
    // R8
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask));

endmodule

// File: rtl/irqf_irq_combine.sv
module irqf_irq_combine #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] mask,
    output logic         irq
);
    typedef struct packed {
        logic irq;
    } irq_t;

    irq_t i_d, i_q;

    always_comb begin
        i_d     = i_q;
        i_d.irq = |(raw & ~mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) i_q <= '0;
        else        i_q <= i_d;
    end

    assign irq = i_q.irq;

    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & ~mask) == '0) |=> !irq);
    // R6
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw & ~mask) != '0) |=> irq);

endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
    import irqf_pkg::*;
#(
    parameter int unsigned WIDTH  = DEF_WIDTH,
    parameter int unsigned RX_BIT = DEF_RX_BIT,
    parameter int unsigned TX_BIT = DEF_TX_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [WIDTH-1:0] reg_wdata,
    output logic [WIDTH-1:0] reg_rdata,
    input  logic [WIDTH-1:0] evt_pulse,
    input  logic             rx_req_lvl,
    input  logic             tx_req_lvl,
    output logic             irq_o
);
    regsel_e          sel;
    logic             flag_wr;
    logic             mask_wr;
    logic [WIDTH-1:0] raw_flags;
    logic [WIDTH-1:0] mask_val;

    always_comb begin
        sel       = regsel_e'(reg_sel);
        flag_wr   = reg_wr && (sel == SEL_FLAGS);
        mask_wr   = reg_wr && (sel == SEL_MASK);
        reg_rdata = (sel == SEL_MASK) ? mask_val : raw_flags;
    end

    irqf_flag_bank #(.W(WIDTH), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_en  (flag_wr),
        .clr_bits(reg_wdata),
        .evt     (evt_pulse),
        .rx_lvl  (rx_req_lvl),
        .tx_lvl  (tx_req_lvl),
        .raw     (raw_flags)
    );

    irqf_mask_reg #(.W(WIDTH)) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (mask_wr),
        .wdata (reg_wdata),
        .mask  (mask_val)
    );

    irqf_irq_combine #(.W(WIDTH)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_flags),
        .mask  (mask_val),
        .irq   (irq_o)
    );

    // R5
    rx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_flags[RX_BIT] == rx_req_lvl) && (raw_flags[TX_BIT] == tx_req_lvl));

endmodule

// File: tb/sim_irq_flag_unit.sv
module sim_irq_flag_unit;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic        sel;
        logic [15:0] wdata;
        logic [15:0] evt;
        logic        rx;
        logic        tx;
        logic [15:0] xf;
        logic [15:0] xm;
        logic        xi;
    } vec_t;

    // wr sel wdata evt rx tx | flags mask irq
    localparam vec_t VECS [14] = '{
        '{1'b0,1'b0,16'h0000,16'h0001,1'b0,1'b0,16'h0001,16'hFFFF,1'b0}, // R7 masked flag visible
        '{1'b0,1'b0,16'h0000,16'h0084,1'b0,1'b0,16'h0085,16'hFFFF,1'b0}, // R9 bits 2,7 latch
        '{1'b1,1'b1,16'hFFFE,16'h0000,1'b0,1'b0,16'h0085,16'hFFFE,1'b1}, // unmask bit 0
        '{1'b1,1'b0,16'h0001,16'h0000,1'b0,1'b0,16'h0084,16'hFFFE,1'b0}, // R3 clear bit 0
        '{1'b1,1'b0,16'h0000,16'h0000,1'b0,1'b0,16'h0084,16'hFFFE,1'b0}, // R3 zeros do nothing
        '{1'b0,1'b0,16'h0000,16'h0000,1'b1,1'b0,16'h00A4,16'hFFFE,1'b0}, // R5 rx level
        '{1'b1,1'b1,16'hFFDF,16'h0000,1'b1,1'b0,16'h00A4,16'hFFDF,1'b1},
        '{1'b1,1'b0,16'h0020,16'h0000,1'b1,1'b0,16'h00A4,16'hFFDF,1'b1}, // R5 ignores clear
        '{1'b0,1'b0,16'h0000,16'h0000,1'b0,1'b1,16'h00C4,16'hFFDF,1'b0}, // R5 tx level
        '{1'b0,1'b0,16'h0000,16'h0060,1'b0,1'b0,16'h0084,16'hFFDF,1'b0}, // R5 ignores pulses
        '{1'b1,1'b0,16'h0004,16'h0004,1'b0,1'b0,16'h0084,16'hFFDF,1'b0}, // R4 event beats clear
        '{1'b1,1'b1,16'hFFFB,16'h0000,1'b0,1'b0,16'h0084,16'hFFFB,1'b1},
        '{1'b1,1'b0,16'hFFFF,16'h0000,1'b0,1'b0,16'h0000,16'hFFFB,1'b0}, // R3 clear all
        '{1'b1,1'b1,16'hFFFF,16'h0000,1'b0,1'b0,16'h0000,16'hFFFF,1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] evt_pulse = '0;
    logic        rx_req_lvl = 1'b0;
    logic        tx_req_lvl = 1'b0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .rx_req_lvl(rx_req_lvl), .tx_req_lvl(tx_req_lvl), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic s, output logic [15:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        read_reg(1'b0, v); check("R1 flags", v, 16'h0000);
        read_reg(1'b1, v); check("R1 mask", v, 16'hFFFF);
        check("R1 irq", {15'd0, irq_o}, 16'h0000);
        rst_n = 1'b1;
        @(posedge clk); #1;

        for (int k = 0; k < 14; k++) begin
            reg_wr     = VECS[k].wr;
            reg_sel    = VECS[k].sel;
            reg_wdata  = VECS[k].wdata;
            evt_pulse  = VECS[k].evt;
            rx_req_lvl = VECS[k].rx;
            tx_req_lvl = VECS[k].tx;
            @(posedge clk); #1;
            reg_wr = 1'b0; evt_pulse = '0; reg_wdata = '0;
            read_reg(1'b0, v); check("R2 flags", v, VECS[k].xf);
            read_reg(1'b1, v); check("R8 mask", v, VECS[k].xm);
            @(posedge clk); #1;
            check("R6 irq", {15'd0, irq_o}, {15'd0, VECS[k].xi});
        end

        // R2 flag holds over idle cycles
        evt_pulse = 16'h8000;
        @(posedge clk); #1;
        evt_pulse = '0;
        repeat (5) @(posedge clk);
        #1;
        read_reg(1'b0, v); check("R2 hold", v, 16'h8000);

        // R6 one-cycle latency after unmask
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h7FFF;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        check("R6 latency low", {15'd0, irq_o}, 16'h0000);
        @(posedge clk); #1;
        check("R6 latency high", {15'd0, irq_o}, 16'h0001);

        // R8 flag write leaves mask
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h8000;
        @(posedge clk); #1;
        reg_wr = 1'b0;
        read_reg(1'b1, v); check("R8 mask kept", v, 16'h7FFF);
        read_reg(1'b0, v); check("R3 cleared", v, 16'h0000);

        // R1 reset mid-run
        evt_pulse = 16'h0003;
        @(posedge clk); #1;
        evt_pulse = '0;
        rst_n = 1'b0;
        @(posedge clk); #1;
        read_reg(1'b0, v); check("R1 flags again", v, 16'h0000);
        read_reg(1'b1, v); check("R1 mask again", v, 16'hFFFF);
        check("R1 irq again", {15'd0, irq_o}, 16'h0000);

        finish_run();
    end

endmodule